// File: doc/BRIEF.md
# Wavefront Vector Register File

This block holds the vector registers of one SIMD unit. A wavefront is 64 work-items wide, but the datapath behind the file is only 16 lanes wide. The storage is therefore viewed as 64 columns, one per work-item. A vector register is one row across all 64 columns, and every column holds 256 rows of 32 bits. Each wavefront owns a contiguous window of rows. The window is given by a base row and a register count, both supplied by the allocator on every request. A window of N rows lets floor(256 / N) wavefronts share the file side by side.

A request names a base, a count, a register index, a direction and a 64-bit write mask. Once the request is accepted, the block forms the physical row, checks it against the window and then runs four quarter-wave passes on consecutive cycles.

- On a write, the caller supplies 16 lanes of data in each pass. The caller uses the quarter index output to select which 16 lanes to supply.
- On a read, each pass returns 16 lanes one cycle later, tagged with the same quarter index.

A request whose register index lies outside its window is flagged. A flagged write is dropped and a flagged read returns zeros. A new request can be accepted during the final pass, so accesses can follow each other with no idle cycle.

Top module: `vrf_wave_regfile`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `pass_valid` and `rd_valid` are all low.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge. The first pass is visible in the next cycle with `pass_valid` high and `pass_quarter` equal to 0. This holds even when acceptance happens during the final pass of a previous access.
- R3: After acceptance, passes run on four consecutive cycles with `pass_quarter` equal to 0, 1, 2 and 3. Quarter q carries work-items 16q to 16q+15, and lane l of the 16-lane buses is work-item 16q+l.
- R4: `busy` is high during passes with quarter 0, 1 and 2, and low during quarter 3 and when idle. A request presented while `busy` is high is ignored and starts no passes.
- R5: The physical row is `req_base + req_index`, and all 16 lanes of every pass use that one row. Two requests that reach the same physical row through different base and index pairs access the same data.
- R6: An access is out of window when `req_index >= req_count`, or when `req_base + req_index >= 256`. Such an access holds `pass_err` high for all four passes. If it is a write, it changes no storage. If it is a read, it returns `rd_err` high with all-zero `rd_data`.
- R7: In pass q of a write, lane l is stored only if `req_mask` bit 16q+l was set at acceptance. Lane l's data is taken from `wr_data` bits [32l+31:32l] in that pass cycle.
- R8: For each pass of a read, `rd_valid` is high in the following cycle, with `rd_quarter` equal to that pass's quarter. `rd_data` holds the 16 stored words of that quarter, lane l in bits [32l+31:32l]. A write access never raises `rd_valid`.
- R9: Wavefronts with disjoint windows, such as three windows of 84 rows at bases 0, 84 and 168, keep independent contents for the same register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_base | input | 8 | First row of the wavefront's window |
| req_count | input | 9 | Number of rows allocated to the wavefront |
| req_index | input | 8 | Register index within the window |
| req_mask | input | 64 | Per-work-item write enable, bit c for work-item c |
| wr_data | input | 512 | Write data for the current pass, 16 lanes of 32 bits |
| busy | output | 1 | High while a new request cannot be accepted |
| pass_valid | output | 1 | A quarter pass is being issued this cycle |
| pass_quarter | output | 2 | Quarter index of the current pass |
| pass_err | output | 1 | Current access is out of window |
| rd_valid | output | 1 | Read data for one quarter is on `rd_data` |
| rd_quarter | output | 2 | Quarter index of the returned read data |
| rd_err | output | 1 | Returned read belongs to an out-of-window access |
| rd_data | output | 512 | Read data, 16 lanes of 32 bits |

## Verification
The assertions check the pass sequencing on every cycle:
- the step from acceptance to quarter 0, and the strict 0-1-2-3 advance;
- that `busy` is only raised inside an access;
- that `pass_err` is stable across an access;
- the one-cycle lag and the quarter tag of read returns;
- zero data on flagged reads;
- that no storage write enable fires during a flagged access.

Whether data lands in the right row and lanes is shown only by the bench's scenarios, because the properties do not model the storage. These scenarios cover:
- the base-plus-index address;
- the lane mask slicing;
- isolation between adjacent windows;
- that a dropped or ignored write really left storage unchanged.

// File: rtl/vrf_pkg.sv
// Package: vrf_pkg
// Shared default geometry for the wavefront vector register file.
// Assumes the wavefront width is an integer multiple of the lane count.
package vrf_pkg;
    localparam int VRF_LANES = 16;   // datapath width in work-items
    localparam int VRF_WAVE  = 64;   // work-items per wavefront
    localparam int VRF_ROWS  = 256;  // registers per column
    localparam int VRF_DW    = 32;   // bits per register
endpackage

// File: rtl/vrf_addr.sv
// Module: vrf_addr
// Forms the physical row from a window base and a register index, and
// flags accesses outside the window or beyond the end of the file.
// Purely combinational; assumes ROWS is a power of two.
module vrf_addr #(
    parameter int ROWS = 256,
    localparam int RW = $clog2(ROWS)
) (
    input  logic [RW-1:0] base,
    input  logic [RW:0]   count,
    input  logic [RW-1:0] index,
    output logic [RW-1:0] row,
    output logic          err
);
    logic [RW:0] sum;

    // Sum and range checks for one request
    always_comb begin
        sum = {1'b0, base} + {1'b0, index};
        row = sum[RW-1:0];
        err = ({1'b0, index} >= count) || (sum >= (RW+1)'(ROWS));
    end
endmodule

// File: rtl/vrf_seq.sv
// Module: vrf_seq
// Quarter-pass sequencer: after a start pulse issues QUARTERS passes on
// consecutive cycles. A start during the last pass restarts at quarter 0.
// Assumes start is only raised while busy is low.
module vrf_seq #(
    parameter int QUARTERS = 4,
    localparam int QW = (QUARTERS > 1) ? $clog2(QUARTERS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          active,
    output logic [QW-1:0] quarter,
    output logic          busy
);
    logic last;

    // Last-pass detect and acceptance gate
    always_comb begin
        last = (quarter == QW'(QUARTERS-1));
        busy = active && !last;
    end

    // Pass counter state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            quarter <= '0;
        end else if (start) begin
            active  <= 1'b1;
            quarter <= '0;
        end else if (active) begin
            if (last) begin
                active  <= 1'b0;
                quarter <= '0;
            end else begin
                quarter <= quarter + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vrf_bank.sv
// Module: vrf_bank
// Storage for one quarter of the columns: ROWS rows of LANES words.
// Per-lane masked write; registered read (data one cycle after re).
// Storage is not reset; read data holds when re is low.
module vrf_bank #(
    parameter int LANES = 16,
    parameter int ROWS  = 256,
    parameter int DW    = 32,
    localparam int RW = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                we,
    input  logic                re,
    input  logic [RW-1:0]       addr,
    input  logic [LANES-1:0]    lane_mask,
    input  logic [LANES*DW-1:0] wdata,
    output logic [LANES*DW-1:0] rdata
);
    logic [LANES*DW-1:0] mem [ROWS];

    // Masked write and registered read of one row
    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_mask[l]) begin
                    mem[addr][l*DW +: DW] <= wdata[l*DW +: DW];
                end
            end
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/vrf_wave_regfile.sv
// Module: vrf_wave_regfile
// Vector register file for one SIMD: wavefronts of WAVE work-items are
// served in WAVE/LANES quarter passes over a LANES-wide datapath. All lanes
// of an access share one row, base + index. Out-of-window accesses are
// flagged; their writes are dropped and their reads return zero.
// Assumes the caller presents wr_data for quarter pass_quarter during
// each pass of a write.
module vrf_wave_regfile #(
    parameter int LANES = vrf_pkg::VRF_LANES,
    parameter int WAVE  = vrf_pkg::VRF_WAVE,
    parameter int ROWS  = vrf_pkg::VRF_ROWS,
    parameter int DW    = vrf_pkg::VRF_DW,
    localparam int QUARTERS = WAVE / LANES,
    localparam int QW = (QUARTERS > 1) ? $clog2(QUARTERS) : 1,
    localparam int RW = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [RW-1:0]       req_base,
    input  logic [RW:0]         req_count,
    input  logic [RW-1:0]       req_index,
    input  logic [WAVE-1:0]     req_mask,
    input  logic [LANES*DW-1:0] wr_data,
    output logic                busy,
    output logic                pass_valid,
    output logic [QW-1:0]       pass_quarter,
    output logic                pass_err,
    output logic                rd_valid,
    output logic [QW-1:0]       rd_quarter,
    output logic                rd_err,
    output logic [LANES*DW-1:0] rd_data
);
    logic                start;
    logic [RW-1:0]       calc_row;
    logic                calc_err;
    logic [RW-1:0]       row_q;
    logic                err_q;
    logic                wr_q;
    logic [WAVE-1:0]     mask_q;
    logic                active;
    logic [QW-1:0]       quarter;
    logic [QUARTERS-1:0] bank_we;
    logic [QUARTERS-1:0] bank_re;
    logic [LANES*DW-1:0] bank_rdata [QUARTERS];

    // Acceptance of a new request
    assign start = req_valid && !busy;

    vrf_addr #(.ROWS(ROWS)) u_addr (
        .base  (req_base),
        .count (req_count),
        .index (req_index),
        .row   (calc_row),
        .err   (calc_err)
    );

    vrf_seq #(.QUARTERS(QUARTERS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .active  (active),
        .quarter (quarter),
        .busy    (busy)
    );

    // Capture the access descriptor at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            err_q  <= 1'b0;
            wr_q   <= 1'b0;
            mask_q <= '0;
        end else if (start) begin
            row_q  <= calc_row;
            err_q  <= calc_err;
            wr_q   <= req_write;
            mask_q <= req_mask;
        end
    end

    generate
        for (genvar q = 0; q < QUARTERS; q++) begin : g_bank
            // Enables for the bank that owns quarter q
            assign bank_we[q] = active && wr_q && !err_q && (quarter == QW'(q));
            assign bank_re[q] = active && !wr_q && !err_q && (quarter == QW'(q));

            vrf_bank #(.LANES(LANES), .ROWS(ROWS), .DW(DW)) u_bank (
                .clk       (clk),
                .we        (bank_we[q]),
                .re        (bank_re[q]),
                .addr      (row_q),
                .lane_mask (mask_q[q*LANES +: LANES]),
                .wdata     (wr_data),
                .rdata     (bank_rdata[q])
            );
        end
    endgenerate

    // Read return tagging, one cycle behind the pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_quarter <= '0;
            rd_err     <= 1'b0;
        end else begin
            rd_valid   <= active && !wr_q;
            rd_quarter <= quarter;
            rd_err     <= active && !wr_q && err_q;
        end
    end

    // Output steering
    always_comb begin
        pass_valid   = active;
        pass_quarter = quarter;
        pass_err     = active && err_q;
        rd_data      = rd_err ? '0 : bank_rdata[rd_quarter];
    end
endmodule

// File: rtl/vrf_wave_regfile_checker.sv
// Module: vrf_wave_regfile_checker
// Temporal checks on the pass sequencing and error handling of
// vrf_wave_regfile; attached to every instance by the bind below.
module vrf_wave_regfile_checker #(
    parameter int QUARTERS = 4,
    parameter int LANES = 16,
    parameter int DW = 32,
    localparam int QW = (QUARTERS > 1) ? $clog2(QUARTERS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                busy,
    input logic                pass_valid,
    input logic [QW-1:0]       pass_quarter,
    input logic                pass_err,
    input logic                rd_valid,
    input logic [QW-1:0]       rd_quarter,
    input logic                rd_err,
    input logic [LANES*DW-1:0] rd_data,
    input logic [QUARTERS-1:0] bank_we
);
    a_r2_first_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (pass_valid && pass_quarter == '0));

    a_r3_quarter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pass_quarter != QW'(QUARTERS-1))
        |=> (pass_valid && pass_quarter == QW'($past(pass_quarter) + 1'b1)));

    a_r4_busy_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pass_valid && pass_quarter != QW'(QUARTERS-1)));

    a_r6_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pass_quarter != QW'(QUARTERS-1)) |=> $stable(pass_err));

    a_r6_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        pass_err |-> (bank_we == '0));

    a_r6_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == '0));

    a_r8_return_lag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(pass_valid) && rd_quarter == $past(pass_quarter)));

    a_r7_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
endmodule

bind vrf_wave_regfile vrf_wave_regfile_checker #(
    .QUARTERS(QUARTERS), .LANES(LANES), .DW(DW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .pass_valid   (pass_valid),
    .pass_quarter (pass_quarter),
    .pass_err     (pass_err),
    .rd_valid     (rd_valid),
    .rd_quarter   (rd_quarter),
    .rd_err       (rd_err),
    .rd_data      (rd_data),
    .bank_we      (bank_we)
);

// File: tb/tb_vrf_wave_regfile.sv
`timescale 1ns/1ps
module tb_vrf_wave_regfile;
    typedef struct packed {
        logic        wr;
        logic [7:0]  base;
        logic [8:0]  cnt;
        logic [7:0]  idx;
        logic [63:0] mask;
        logic [7:0]  seed;
    } vec_t;

    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'd0,   9'd84,  8'd0,  ALL, 8'h11},                   // R9 window 0
        '{1'b1, 8'd84,  9'd84,  8'd0,  ALL, 8'h22},                   // R9 window 1
        '{1'b1, 8'd168, 9'd84,  8'd0,  ALL, 8'h33},                   // R9 window 2
        '{1'b0, 8'd0,   9'd84,  8'd0,  64'd0, 8'h00},
        '{1'b0, 8'd84,  9'd84,  8'd0,  64'd0, 8'h00},
        '{1'b0, 8'd168, 9'd84,  8'd0,  64'd0, 8'h00},
        '{1'b1, 8'd10,  9'd20,  8'd5,  ALL, 8'h44},                   // R5 row 15
        '{1'b1, 8'd10,  9'd20,  8'd5,  64'hF0F0_0000_FFFF_0001, 8'h55}, // R7 partial
        '{1'b0, 8'd15,  9'd4,   8'd0,  64'd0, 8'h00},                 // R5 alias read
        '{1'b1, 8'd30,  9'd1,   8'd0,  ALL, 8'h66},                   // preload row 30
        '{1'b1, 8'd10,  9'd20,  8'd20, ALL, 8'h77},                   // R6 idx==count
        '{1'b0, 8'd30,  9'd1,   8'd0,  64'd0, 8'h00},                 // row 30 unchanged
        '{1'b1, 8'd4,   9'd1,   8'd0,  ALL, 8'h88},                   // preload row 4
        '{1'b1, 8'd200, 9'd100, 8'd60, ALL, 8'h99},                   // R6 overflow -> row 4
        '{1'b0, 8'd4,   9'd1,   8'd0,  64'd0, 8'h00},                 // row 4 unchanged
        '{1'b0, 8'd10,  9'd20,  8'd25, 64'd0, 8'h00},                 // R6 read out of window
        '{1'b0, 8'd200, 9'd100, 8'd60, 64'd0, 8'h00}                  // R6 read overflow
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_base = '0;
    logic [8:0]   req_count = '0;
    logic [7:0]   req_index = '0;
    logic [63:0]  req_mask = '0;
    logic [511:0] wr_data = '0;
    logic         busy, pass_valid, pass_err, rd_valid, rd_err;
    logic [1:0]   pass_quarter, rd_quarter;
    logic [511:0] rd_data;

    int nvec = 0;
    int nfail = 0;
    logic [31:0] mdl [int];

    always #2.5 clk = ~clk;

    vrf_wave_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_base(req_base), .req_count(req_count), .req_index(req_index),
        .req_mask(req_mask), .wr_data(wr_data), .busy(busy),
        .pass_valid(pass_valid), .pass_quarter(pass_quarter), .pass_err(pass_err),
        .rd_valid(rd_valid), .rd_quarter(rd_quarter), .rd_err(rd_err),
        .rd_data(rd_data)
    );

    function automatic logic [31:0] dval(input logic [7:0] seed, input int col);
        return {seed, 8'(col), ~seed, 8'(col) ^ 8'h3C};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access; intrude = present a request while busy, chain = issue
    // the next request during the last pass
    task automatic run_access(input vec_t v, input bit intrude, input bit chain);
        bit exp_err;
        int row;
        exp_err = (v.idx >= v.cnt) || (int'(v.base) + int'(v.idx) >= 256);
        row = (int'(v.base) + int'(v.idx)) % 256;
        @(negedge clk);
        chk(busy == 1'b0, "R4", "idle busy", 64'(busy), 64'd0);
        req_valid = 1'b1; req_write = v.wr; req_base = v.base;
        req_count = v.cnt; req_index = v.idx; req_mask = v.mask;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(negedge clk);
            if (k < 4) begin
                chk(pass_valid == 1'b1, "R3", "pass_valid", 64'(pass_valid), 64'd1);
                chk(pass_quarter == 2'(k), "R3", "pass_quarter", 64'(pass_quarter), 64'(k));
                chk(pass_err == exp_err, "R6", "pass_err", 64'(pass_err), 64'(exp_err));
                chk(busy == (k < 3), "R4", "busy in pass", 64'(busy), 64'(k < 3));
                for (int l = 0; l < 16; l++) wr_data[l*32 +: 32] = dval(v.seed, k*16 + l);
                if (v.wr && !exp_err) begin
                    for (int l = 0; l < 16; l++)
                        if (v.mask[k*16 + l]) mdl[row*64 + k*16 + l] = dval(v.seed, k*16 + l);
                end
            end
            if (k >= 1) begin
                if (v.wr) begin
                    chk(rd_valid == 1'b0, "R8", "rd_valid on write", 64'(rd_valid), 64'd0);
                end else begin
                    chk(rd_valid == 1'b1, "R8", "rd_valid", 64'(rd_valid), 64'd1);
                    chk(rd_quarter == 2'(k-1), "R8", "rd_quarter", 64'(rd_quarter), 64'(k-1));
                    chk(rd_err == exp_err, "R6", "rd_err", 64'(rd_err), 64'(exp_err));
                    for (int l = 0; l < 16; l++) begin
                        int key;
                        key = row*64 + (k-1)*16 + l;
                        if (exp_err)
                            chk(rd_data[l*32 +: 32] == 32'd0, "R6", "zero read",
                                64'(rd_data[l*32 +: 32]), 64'd0);
                        else if (mdl.exists(key))
                            chk(rd_data[l*32 +: 32] == mdl[key], "R7", "read lane",
                                64'(rd_data[l*32 +: 32]), 64'(mdl[key]));
                    end
                end
            end
            if (intrude && k == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_base = 8'd4;
                req_count = 9'd1; req_index = 8'd0; req_mask = ALL;
            end
            if (intrude && k == 2) req_valid = 1'b0;
            if (chain && k == 3) begin
                req_valid = 1'b1; req_write = 1'b0; req_base = 8'd4;
                req_count = 9'd1; req_index = 8'd0; req_mask = '0;
            end
            if (k == 4) begin
                if (chain) begin
                    chk(pass_valid && pass_quarter == 2'd0, "R2", "back-to-back start",
                        64'({pass_valid, pass_quarter}), 64'h4);
                    req_valid = 1'b0;
                    repeat (4) @(negedge clk);
                end else begin
                    chk(pass_valid == 1'b0, intrude ? "R4" : "R3", "quiet after access",
                        64'(pass_valid), 64'd0);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
        chk(pass_valid == 1'b0, "R1", "pass_valid in reset", 64'(pass_valid), 64'd0);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && pass_valid == 1'b0, "R1", "idle after reset",
            64'({busy, pass_valid}), 64'd0);

        // Vector table walk: R2 R3 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            // intrude on entry 13 and rely on entry 14 to show row 4 kept
            run_access(VEC[i], i == 13, 1'b0);
        end

        // R4: request while busy ignored; row 4 must still hold seed 88
        run_access(VEC[11], 1'b1, 1'b0);
        run_access(VEC[14], 1'b0, 1'b0);

        // R2: acceptance during the last pass gives a back-to-back access
        run_access(VEC[8], 1'b0, 1'b1);
        run_access(VEC[3], 1'b0, 1'b0);

        // R1: reset in the middle of an access returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_base = 8'd0;
        req_count = 9'd84; req_index = 8'd0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(pass_valid == 1'b0 && busy == 1'b0 && rd_valid == 1'b0, "R1", "mid-access reset",
            64'({pass_valid, busy, rd_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule